// File: doc/BRIEF.md
# Latched On/Off Time PWM Generator

This block drives a pulse-width-modulated output whose high phase and low phase each come from their own 16-bit tick count. A host loads the counts one byte at a time. Three of the four bytes only go into holding registers. Writing the on-time high byte copies all four bytes into a shadow pair in one step, so the running waveform never sees a half-written time. Every period starts with the on phase and ends with the off phase. The counters move only on cycles where a timebase tick is present.

A run is started and stopped through an enable bit, and that bit reads back on an output. In continuous mode the periods repeat. In single-period mode the block runs one full period and then clears its own enable bit. When a gating input is set, the output is also ANDed with an externally supplied PWM signal. Shadow values written during a period are held back until the next period boundary, so each period keeps the on and off times it started with.

Top module: `pwm_latched_gen`

## Requirements
- R1: Byte writes use `wr_sel_i` as follows: 0 = off-time low byte, 1 = off-time high byte, 2 = on-time low byte, 3 = on-time high byte. Each time is `{high byte, low byte}`, counted in ticks.
- R2: A write with select 3 copies the staged bytes, together with the written data, into the shadow on and off times. Writes with selects 0 to 2 leave the shadow times and the waveform unchanged. After reset both shadow times are zero.
- R3: The phase counters advance only on clock cycles where `tick_i` is 1. A phase of N ticks lasts until the N-th tick.
- R4: The first clock edge with `en_o` = 1 and the block idle starts a period, and `pwm_o` goes high on the following cycle. Each period is the on phase (output high) followed by the off phase (output low). While `en_o` is 0, `pwm_o` is 0.
- R5: The shadow times are copied into the running period only when a period starts. A latch during a period takes effect at the next period.
- R6: An on time of zero gives a constant low output. An off time of zero gives a constant high output while the block is enabled. If both times are zero, the output stays low and each tick ends a period.
- R7: With `mode_i` = 0, periods repeat back to back for as long as the block is enabled.
- R8: With `mode_i` = 1, the tick that ends the first period clears `en_o` to 0, and the output then stays low.
- R9: With `gate_i` = 1, `pwm_o` is the internal waveform ANDed with `ext_pwm_i`. With `gate_i` = 0, `ext_pwm_i` is ignored.
- R10: A cycle with `en_wr_i` = 1 loads `en_val_i` into the enable bit, and `en_o` shows it on the next cycle. A host write takes priority over the single-period clear. Writing 0 stops the output on the next cycle.
- R11: While reset is asserted, and after it is released, `en_o` and `pwm_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timebase tick; counters step when 1 |
| wr_en_i | input | 1 | Byte write strobe |
| wr_sel_i | input | 2 | Byte select (see R1) |
| wr_data_i | input | 8 | Byte write data |
| en_wr_i | input | 1 | Enable bit write strobe |
| en_val_i | input | 1 | Value written to the enable bit |
| mode_i | input | 1 | 0 = continuous, 1 = single period |
| gate_i | input | 1 | 1 = AND the output with `ext_pwm_i` |
| ext_pwm_i | input | 1 | External PWM signal used for gating |
| pwm_o | output | 1 | PWM output |
| en_o | output | 1 | Enable bit read-back |

## Verification
The bench targets four corner cases.

- **Mid-period latch.** Staged bytes are written, and the on-time high byte lands in the middle of a period. If the latch were applied at once, the current period would be cut short. If the partial bytes leaked through, the output would change before the commit write.
- **Zero times and wide counts.** Zero on, zero off and both zero are tried, along with counts above 255 that exercise the high byte. Off-by-one counting or a missed high byte shows up as a shifted edge or a stuck output.
- **Sparse ticks.** Ticks arrive only every third cycle. A counter that stepped on every clock would end its phases early.
- **Single-period mode and gating.** The bench checks that the enable bit drops exactly after one period, that the output never restarts, and that gating with a low external signal forces the output low.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_OFF   = 2'd2,
    PH_EMPTY = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_OFF_LO = 2'd0;
  localparam logic [1:0] SEL_OFF_HI = 2'd1;
  localparam logic [1:0] SEL_ON_LO  = 2'd2;
  localparam logic [1:0] SEL_ON_HI  = 2'd3;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_time_regs.sv
module pwm_time_regs
  import pwm_gen_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  on_sh_o,
  output logic [CNT_W-1:0]  off_sh_o
);

  logic [BYTE_W-1:0] off_lo_q, off_lo_d;
  logic [BYTE_W-1:0] off_hi_q, off_hi_d;
  logic [BYTE_W-1:0] on_lo_q,  on_lo_d;
  logic [CNT_W-1:0]  on_sh_q,  on_sh_d;
  logic [CNT_W-1:0]  off_sh_q, off_sh_d;
  logic              commit;

  assign commit = wr_en_i && (wr_sel_i == SEL_ON_HI);

  always_comb begin
    off_lo_d = off_lo_q;
    off_hi_d = off_hi_q;
    on_lo_d  = on_lo_q;
    on_sh_d  = on_sh_q;
    off_sh_d = off_sh_q;
    if (wr_en_i) begin
      case (wr_sel_i)
        SEL_OFF_LO: off_lo_d = wr_data_i;
        SEL_OFF_HI: off_hi_d = wr_data_i;
        SEL_ON_LO:  on_lo_d  = wr_data_i;
        default:    ;
      endcase
    end
    if (commit) begin
      on_sh_d  = {wr_data_i, on_lo_q};
      off_sh_d = {off_hi_q, off_lo_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_lo_q <= '0;
      off_hi_q <= '0;
      on_lo_q  <= '0;
      on_sh_q  <= '0;
      off_sh_q <= '0;
    end else begin
      off_lo_q <= off_lo_d;
      off_hi_q <= off_hi_d;
      on_lo_q  <= on_lo_d;
      on_sh_q  <= on_sh_d;
      off_sh_q <= off_sh_d;
    end
  end

  assign on_sh_o  = on_sh_q;
  assign off_sh_o = off_sh_q;

  // R2: shadow times move only on a commit write
  p_shadow_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(on_sh_q) && $stable(off_sh_q)));

  // R2: commit takes the written byte as the on-time high byte
  p_commit_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (on_sh_q[CNT_W-1:BYTE_W] == $past(wr_data_i)));

endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] on_sh_i,
  input  logic [CNT_W-1:0] off_sh_i,
  output logic             phase_on_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] off_q, off_d;
  logic             restart;
  logic             period_end;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    off_d      = off_q;
    restart    = 1'b0;
    period_end = 1'b0;
    done_o     = 1'b0;

    if (!en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: restart = 1'b1;
        PH_ON: begin
          if (tick_i) begin
            if (cnt_q == CNT_ONE) begin
              if (off_q != '0) begin
                phase_d = PH_OFF;
                cnt_d   = off_q;
              end else begin
                period_end = 1'b1;
              end
            end else begin
              cnt_d = cnt_q - CNT_ONE;
            end
          end
        end
        PH_OFF: begin
          if (tick_i) begin
            if (cnt_q == CNT_ONE) period_end = 1'b1;
            else                  cnt_d = cnt_q - CNT_ONE;
          end
        end
        default: begin
          if (tick_i) period_end = 1'b1;
        end
      endcase

      if (period_end) begin
        if (mode_i) begin
          done_o  = 1'b1;
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          restart = 1'b1;
        end
      end

      if (restart) begin
        off_d = off_sh_i;
        if (on_sh_i != '0) begin
          phase_d = PH_ON;
          cnt_d   = on_sh_i;
        end else if (off_sh_i != '0) begin
          phase_d = PH_OFF;
          cnt_d   = off_sh_i;
        end else begin
          phase_d = PH_EMPTY;
          cnt_d   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      off_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      off_q   <= off_d;
    end
  end

  assign phase_on_o = (phase_q == PH_ON);

  // R3: without a tick a running phase holds its count and phase
  p_tick_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && phase_q != PH_IDLE) |=> ($stable(cnt_q) && $stable(phase_q)));

  // R4: a disabled block drops back to idle
  p_idle_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == PH_IDLE));

  // R8: completion is signalled only in single-period mode
  p_done_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mode_i);

endmodule

// File: rtl/pwm_en_ctl.sv
module pwm_en_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic en_val_i,
  input  logic done_i,
  input  logic phase_on_i,
  input  logic gate_i,
  input  logic ext_pwm_i,
  output logic en_o,
  output logic pwm_o
);

  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (en_wr_i)     en_d = en_val_i;
    else if (done_i) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o  = en_q;
  assign pwm_o = en_q && phase_on_i && (!gate_i || ext_pwm_i);

  // R8: single-period completion clears the enable bit
  p_oneshot_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !en_wr_i) |=> !en_q);

  // R10: host write lands on the next cycle
  p_host_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> (en_q == $past(en_val_i)));

endmodule

// File: rtl/pwm_latched_gen.sv
module pwm_latched_gen #(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              en_wr_i,
  input  logic              en_val_i,
  input  logic              mode_i,
  input  logic              gate_i,
  input  logic              ext_pwm_i,
  output logic              pwm_o,
  output logic              en_o
);

  logic             rst_n;
  logic [CNT_W-1:0] on_sh;
  logic [CNT_W-1:0] off_sh;
  logic             phase_on;
  logic             done;
  logic             en_int;

  pwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pwm_time_regs #(.BYTE_W(BYTE_W)) u_times (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .on_sh_o   (on_sh),
    .off_sh_o  (off_sh)
  );

  pwm_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (en_int),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .on_sh_i    (on_sh),
    .off_sh_i   (off_sh),
    .phase_on_o (phase_on),
    .done_o     (done)
  );

  pwm_en_ctl u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_wr_i    (en_wr_i),
    .en_val_i   (en_val_i),
    .done_i     (done),
    .phase_on_i (phase_on),
    .gate_i     (gate_i),
    .ext_pwm_i  (ext_pwm_i),
    .en_o       (en_int),
    .pwm_o      (pwm_o)
  );

  assign en_o = en_int;

  // R4: no output while disabled
  p_low_when_off_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_o |-> !pwm_o);

  // R9: a low external signal blocks a gated output
  p_gate_block_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (gate_i && !ext_pwm_i) |-> !pwm_o);

  // R11: nothing runs during reset
  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r11: assert (!pwm_o);
    end
  end

endmodule

// File: tb/pwm_latched_gen_test.sv
`timescale 1ns/1ps
module pwm_latched_gen_test;

  localparam int WIN  = 300;
  localparam int NVEC = 11;

  typedef struct packed {
    logic [15:0] on_t;
    logic [15:0] off_t;
    logic        mode_b;
    logic        gate_b;
    logic        ext_b;
  } vec_t;

  // on, off, mode, gate, ext
  localparam vec_t VECS [0:NVEC-1] = '{
    '{16'd3,   16'd2, 1'b0, 1'b0, 1'b0},
    '{16'd1,   16'd1, 1'b0, 1'b0, 1'b0},
    '{16'd0,   16'd4, 1'b0, 1'b0, 1'b0},
    '{16'd4,   16'd0, 1'b0, 1'b0, 1'b0},
    '{16'd3,   16'd2, 1'b1, 1'b0, 1'b0},
    '{16'd2,   16'd3, 1'b0, 1'b1, 1'b0},
    '{16'd2,   16'd3, 1'b0, 1'b1, 1'b1},
    '{16'd0,   16'd0, 1'b1, 1'b0, 1'b0},
    '{16'd257, 16'd2, 1'b1, 1'b0, 1'b0},
    '{16'd5,   16'd3, 1'b1, 1'b1, 1'b1},
    '{16'd0,   16'd0, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       en_wr;
  logic       en_val;
  logic       mode;
  logic       gate;
  logic       ext;
  logic       pwm;
  logic       en;

  int tests_run = 0;
  int tests_fail = 0;

  always #2.5 clk = ~clk;

  pwm_latched_gen uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .en_wr_i   (en_wr),
    .en_val_i  (en_val),
    .mode_i    (mode),
    .gate_i    (gate),
    .ext_pwm_i (ext),
    .pwm_o     (pwm),
    .en_o      (en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic load_times(input logic [15:0] on_v, input logic [15:0] off_v);
    wr_byte(2'd0, off_v[7:0]);
    wr_byte(2'd1, off_v[15:8]);
    wr_byte(2'd2, on_v[7:0]);
    wr_byte(2'd3, on_v[15:8]);
  endtask

  function automatic logic exp_pwm(input vec_t t, input int j);
    int n_on, n_off, per;
    logic h;
    n_on  = int'(t.on_t);
    n_off = int'(t.off_t);
    per   = n_on + n_off;
    if (t.mode_b) h = (j < n_on);
    else          h = (n_on != 0) && (per != 0) && ((j % per) < n_on);
    return h && (!t.gate_b || t.ext_b);
  endfunction

  function automatic logic exp_en(input vec_t t, input int j);
    int per;
    per = int'(t.on_t) + int'(t.off_t);
    if (per < 1) per = 1;
    if (t.mode_b) return (j < per);
    return 1'b1;
  endfunction

  initial begin
    #(200000 * 5);
    tests_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    logic [15:0] mask;
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
    en_wr = 1'b0; en_val = 1'b0; mode = 1'b0; gate = 1'b0; ext = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "pwm in reset", int'(pwm), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "en after reset", int'(en), 0);

    // R2: staged bytes alone do not latch; shadow is zero so output stays low
    wr_byte(2'd0, 8'd3);
    wr_byte(2'd2, 8'd3);
    set_en(1'b1);
    begin
      int hi = 0;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (pwm) hi++;
      end
      chk("R2", "high cycles before commit", hi, 0);
    end
    wr_byte(2'd3, 8'd0);
    begin
      int seen = 0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (pwm) seen = 1;
      end
      chk("R2", "output rises after commit", seen, 1);
    end

    // R1 R4 R6 R7 R8 R9: vector table
    for (int v = 0; v < NVEC; v++) begin
      int bad_p, bad_e, ap, ep, ae, ee;
      set_en(1'b0);
      mode = VECS[v].mode_b; gate = VECS[v].gate_b; ext = VECS[v].ext_b;
      load_times(VECS[v].on_t, VECS[v].off_t);
      set_en(1'b1);
      bad_p = 0; bad_e = 0; ap = 0; ep = 0; ae = 0; ee = 0;
      for (int j = 0; j < WIN; j++) begin
        @(negedge clk);
        if (pwm !== exp_pwm(VECS[v], j) && bad_p == 0) begin
          bad_p = 1; ap = int'(pwm); ep = int'(exp_pwm(VECS[v], j));
        end
        if (en !== exp_en(VECS[v], j) && bad_e == 0) begin
          bad_e = 1; ae = int'(en); ee = int'(exp_en(VECS[v], j));
        end
      end
      chk("R1/R4/R6/R7/R9", $sformatf("vector %0d pwm", v), ap, ep);
      chk("R8/R10", $sformatf("vector %0d en", v), ae, ee);
    end

    // R5: latch during a period waits for the next boundary
    set_en(1'b0);
    mode = 1'b0; gate = 1'b0;
    load_times(16'd2, 16'd2);
    set_en(1'b1);
    mask = 16'h6F33;
    begin
      int bad = -1;
      for (int j = 0; j < 15; j++) begin
        @(negedge clk);
        if (pwm !== mask[j] && bad < 0) bad = j;
        wr_en = 1'b0;
        if (j == 0) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'd1; end
        if (j == 1) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd0; end
        if (j == 2) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'd4; end
        if (j == 5) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'd0; end
      end
      wr_en = 1'b0;
      chk("R5", "first mismatching window", bad, -1);
    end

    // R3: sparse ticks, on=2 off=1, tick every third cycle
    set_en(1'b0);
    load_times(16'd2, 16'd1);
    tick = 1'b0;
    set_en(1'b1);
    mask = 16'h7E3F;
    begin
      int bad = -1;
      for (int j = 0; j < 15; j++) begin
        @(negedge clk);
        if (pwm !== mask[j] && bad < 0) bad = j;
        tick = ((j % 3) == 2);
      end
      chk("R3", "first mismatching window", bad, -1);
    end
    tick = 1'b1;

    // R10: disabling stops output on the next cycle
    set_en(1'b0);
    load_times(16'd4, 16'd0);
    set_en(1'b1);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (j == 3) begin en_wr = 1'b1; en_val = 1'b0; end
      else en_wr = 1'b0;
      if (j == 2) chk("R10", "pwm before disable", int'(pwm), 1);
      if (j == 4) begin
        chk("R10", "pwm after disable", int'(pwm), 0);
        chk("R10", "en after disable", int'(en), 0);
      end
    end
    en_wr = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

endmodule